// File: doc/BRIEF.md
# Floating-Point Branch Resolver with Delay-Slot Control

This block decides whether a floating-point conditional branch is taken and works out where the instruction stream goes next. The machine has a single delay slot after each branch. Each cycle the pipeline can offer one branch. It supplies the 32-bit branch instruction word, the 2-bit floating-point condition code left by the most recent compare, and the address of the branch itself. In the same cycle the block returns four results: the taken decision, the branch target, a flag telling the pipeline to squash the delay-slot instruction, and the addresses of the next two instructions that will actually execute.

The branch condition field selects one of sixteen conditions. Each condition is a set of the four compare outcomes: equal, less, greater and unordered. The annul bit changes how the delay slot is handled, and it has a special meaning for the unconditional branch. A running count of taken branches is kept in a register and wraps when it overflows.

Top module: `fp_branch_unit`

## Requirements
- R1: Condition code values are equal=0, less=1, greater=2, unordered=3. Instruction bits 28:25 choose the condition, and the branch is taken when the code is a member of the chosen set: 0 {}, 1 {L,G,U}, 2 {L,G}, 3 {L,U}, 4 {L}, 5 {G,U}, 6 {G}, 7 {U}, 8 {E,L,G,U}, 9 {E}, 10 {E,U}, 11 {E,G}, 12 {E,G,U}, 13 {E,L}, 14 {E,L,U}, 15 {E,L,G}.
- R2: `target` is the branch address plus four times instruction bits 21:0, where those bits are read as a signed number. The sum wraps modulo 2^32.
- R3: For a valid branch that is not taken, with annul bit 29 clear: `annul`=0, `npc`=pc+4 and `nnpc`=pc+8.
- R4: For a valid branch that is not taken, with annul bit 29 set: `annul`=1, `npc`=pc+8 and `nnpc`=pc+12.
- R5: For a valid branch with condition 8 and annul bit 29 set: `annul`=1, `npc`=target and `nnpc`=target+4.
- R6: For any other taken branch, including condition 8 with the annul bit clear: `annul`=0, `npc`=pc+4 and `nnpc`=target.
- R7: `taken_cnt` is zero after reset. It increases by exactly one on each rising clock edge where `taken` is high, and it wraps at its width.
- R8: While `valid` is low, `taken` and `annul` are 0 and `taken_cnt` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | A branch is presented this cycle |
| instr | input | 32 | Branch instruction word |
| fcc | input | 2 | Floating-point condition code |
| pc | input | 32 | Address of the branch |
| taken | output | 1 | Branch taken |
| target | output | 32 | Branch target address |
| annul | output | 1 | Squash the delay-slot instruction |
| npc | output | 32 | Next instruction to execute |
| nnpc | output | 32 | Instruction after that |
| taken_cnt | output | 16 | Taken-branch count |

## Verification
Apart from the counter, every decision is combinational, so an error in the condition decode or the target adder shows up on `taken`, `annul`, `npc` and `nnpc` in the same cycle the branch is presented. The bench sweeps all sixteen conditions against all four codes, combines that with random displacements and addresses, and adds directed cases at the displacement extremes and at address wraparound. The counter is the only piece of state. A missed or doubled increment, or an increment while `valid` is low, appears on `taken_cnt` one edge later and stays visible from then on.

// File: rtl/fp_branch_unit.sv
module fp_branch_unit #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DISP_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [31:0]       instr,
  input  logic [1:0]        fcc,
  input  logic [ADDR_W-1:0] pc,
  output logic              taken,
  output logic [ADDR_W-1:0] target,
  output logic              annul,
  output logic [ADDR_W-1:0] npc,
  output logic [ADDR_W-1:0] nnpc,
  output logic [CNT_W-1:0]  taken_cnt
);
  localparam int EXT_W = ADDR_W - DISP_W - 2;
  localparam logic [3:0] COND_ALWAYS = 4'd8;

  logic [3:0] cond;
  logic       abit;
  logic [3:0] hits;
  logic       is_bra;
  logic [ADDR_W-1:0] disp;

  assign cond = instr[28:25];
  assign abit = instr[29];
  assign disp = {{EXT_W{instr[DISP_W-1]}}, instr[DISP_W-1:0], 2'b00};

  always_comb begin
    unique case (cond[2:0])
      3'd0: hits = 4'b0000;
      3'd1: hits = 4'b1110;
      3'd2: hits = 4'b0110;
      3'd3: hits = 4'b1010;
      3'd4: hits = 4'b0010;
      3'd5: hits = 4'b1100;
      3'd6: hits = 4'b0100;
      default: hits = 4'b1000;
    endcase
    if (cond[3]) hits = ~hits;
  end

  assign is_bra = (cond == COND_ALWAYS) && abit;
  assign taken  = valid && hits[fcc];
  assign target = pc + disp;
  assign annul  = valid && ((!taken && abit) || is_bra);

  always_comb begin
    if (!taken) begin
      npc  = abit ? pc + ADDR_W'(8)  : pc + ADDR_W'(4);
      nnpc = abit ? pc + ADDR_W'(12) : pc + ADDR_W'(8);
    end else if (is_bra) begin
      npc  = target;
      nnpc = target + ADDR_W'(4);
    end else begin
      npc  = pc + ADDR_W'(4);
      nnpc = target;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) taken_cnt <= '0;
    else if (taken) taken_cnt <= taken_cnt + CNT_W'(1);
  end
endmodule

// File: rtl/fp_branch_unit_chk.sv
module fp_branch_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid,
  input logic [31:0]       instr,
  input logic [ADDR_W-1:0] pc,
  input logic              taken,
  input logic [ADDR_W-1:0] target,
  input logic              annul,
  input logic [ADDR_W-1:0] npc,
  input logic [ADDR_W-1:0] nnpc,
  input logic [CNT_W-1:0]  taken_cnt
);
  assert_never_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && instr[28:25] == 4'd0) |-> !taken);
  assert_always_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && instr[28:25] == 4'd8) |-> taken);
  assert_nt_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !taken && !instr[29]) |-> (!annul && npc == pc + 4 && nnpc == pc + 8));
  assert_nt_annul_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !taken && instr[29]) |-> (annul && npc == pc + 8 && nnpc == pc + 12));
  assert_bra_annul_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && instr[28:25] == 4'd8 && instr[29]) |-> (annul && npc == target && nnpc == target + 4));
  assert_taken_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !(instr[28:25] == 4'd8 && instr[29])) |-> (!annul && npc == pc + 4 && nnpc == target));
  assert_cnt_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> taken_cnt == $past(taken_cnt) + 1'b1);
  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (!taken && !annul));
  assert_idle_cnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(taken_cnt));
endmodule

bind fp_branch_unit fp_branch_unit_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid(valid), .instr(instr), .pc(pc),
  .taken(taken), .target(target), .annul(annul), .npc(npc), .nnpc(nnpc),
  .taken_cnt(taken_cnt)
);

// File: tb/sim_fp_branch_unit.sv
`timescale 1ns/1ps
module sim_fp_branch_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        valid = 0;
  logic [31:0] instr = 0;
  logic [1:0]  fcc = 0;
  logic [31:0] pc = 0;
  logic        taken, annul;
  logic [31:0] target, npc, nnpc;
  logic [15:0] taken_cnt;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [15:0] exp_cnt = 0;

  fp_branch_unit u0 (.*);

  always #5 clk = ~clk;

  function automatic bit ref_take(input logic [3:0] c, input logic [1:0] f);
    bit e, l, g, u;
    e = (f == 2'd0); l = (f == 2'd1); g = (f == 2'd2); u = (f == 2'd3);
    case (c)
      4'd0: return 0;
      4'd1: return l | g | u;
      4'd2: return l | g;
      4'd3: return l | u;
      4'd4: return l;
      4'd5: return g | u;
      4'd6: return g;
      4'd7: return u;
      4'd8: return 1;
      4'd9: return e;
      4'd10: return e | u;
      4'd11: return e | g;
      4'd12: return e | g | u;
      4'd13: return e | l;
      4'd14: return e | l | u;
      default: return e | l | g;
    endcase
  endfunction

  function automatic logic [31:0] ref_target(input logic [31:0] w, input logic [31:0] p);
    logic signed [31:0] d;
    d = 32'(signed'(w[21:0]));
    return p + (d <<< 2);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input bit v, input logic [31:0] w, input logic [1:0] f, input logic [31:0] p);
    bit t, a, bra;
    logic [31:0] tg, en, enn;
    @(negedge clk);
    valid = v; instr = w; fcc = f; pc = p;
    #1;
    t = v && ref_take(w[28:25], f);
    a = w[29];
    bra = (w[28:25] == 4'd8) && a;
    tg = ref_target(w, p);
    chk("R1 taken", 32'(taken), 32'(t));
    chk("R2 target", target, tg);
    if (!v) begin
      chk("R8 annul idle", 32'(annul), 0);
    end else if (!t && !a) begin
      chk("R3 annul", 32'(annul), 0); chk("R3 npc", npc, p + 4); chk("R3 nnpc", nnpc, p + 8);
    end else if (!t) begin
      chk("R4 annul", 32'(annul), 1); chk("R4 npc", npc, p + 8); chk("R4 nnpc", nnpc, p + 12);
    end else if (bra) begin
      chk("R5 annul", 32'(annul), 1); chk("R5 npc", npc, tg); chk("R5 nnpc", nnpc, tg + 4);
    end else begin
      chk("R6 annul", 32'(annul), 0); chk("R6 npc", npc, p + 4); chk("R6 nnpc", nnpc, tg);
    end
    if (t) exp_cnt = exp_cnt + 1;
    @(posedge clk); #1;
    chk(v ? "R7 count" : "R8 count hold", 32'(taken_cnt), 32'(exp_cnt));
  endtask

  function automatic logic [31:0] mk(input bit a, input logic [3:0] c, input logic [21:0] d);
    return {2'b00, a, c, 3'b110, d};
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset count", 32'(taken_cnt), 0);
    @(negedge clk); rst_n = 1;
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 4; f++)
        for (int a = 0; a < 2; a++)
          apply(1, mk(a[0], c[3:0], 22'h000010), f[1:0], 32'h0000_4000);
    apply(1, mk(0, 4'd8, 22'h1FFFFF), 2'd0, 32'h0000_1000);
    apply(1, mk(1, 4'd8, 22'h200000), 2'd3, 32'h0080_0000);
    apply(1, mk(1, 4'd8, 22'h000004), 2'd1, 32'hFFFF_FFF8);
    apply(0, mk(0, 4'd8, 22'h000004), 2'd0, 32'h0000_0100);
    apply(1, mk(1, 4'd0, 22'h000001), 2'd2, 32'hFFFF_FFF4);
    apply(0, mk(1, 4'd9, 22'h000001), 2'd0, 32'h0000_0200);
    for (int i = 0; i < 400; i++)
      apply(($urandom % 8) != 0, $urandom, 2'($urandom), $urandom);
    apply(1, mk(0, 4'd8, 22'h0), 2'd0, 32'h0);
    exp_cnt = 0;
    @(negedge clk); valid = 0; rst_n = 0;
    @(posedge clk); #1;
    chk("R7 reset clears count", 32'(taken_cnt), 0);
    rst_n = 1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule